// File: doc/BRIEF.md
# Decode-Stage Register Interlock

This block sits beside the decode stage of a five-stage in-order pipeline that has no bypass paths. Every cycle it compares the source register numbers of the instruction being decoded against the destination of each older, register-writing instruction that has not yet reached write-back. On a match, the decoding instruction has to wait. The block then holds the program counter and the fetch/decode register, and it replaces the control word entering the decode/execute register with all zeros.

The block is purely combinational. It keeps no count of bubbles. The pipeline moves the writer one stage further each cycle, and the decision is made again from scratch. A writer one instruction ahead therefore stalls decode for two cycles: first from the execute slot, then from the memory slot. A writer two instructions ahead stalls for one cycle. A writer in write-back needs no stall, because the register file writes in the first half of the cycle and reads in the second. The classifier works out a hazard kind each cycle and the control logic decodes it:

- CLEAR: no match.
- NEAR: the writer is in decode/execute, two bubbles remain.
- FAR: the writer is in execute/memory, one bubble remains.

If both slots match, NEAR wins. The three kinds change only as the pipeline advances, and the possible moves are:

- NEAR to FAR, when the writer moves on.
- FAR to CLEAR.
- CLEAR to either stall kind, when a new dependent instruction arrives.

Top module: `interlock_unit`

## Requirements
- R1: When any decode source register equals `ex_dst_reg` while `ex_reg_write` is 1, `idex_bubble` is 1 (hazard kind NEAR).
- R2: When any decode source register equals `mem_dst_reg` while `mem_reg_write` is 1, `idex_bubble` is 1 (hazard kind FAR).
- R3: When the surrounding pipeline advances on every cycle, a writer one instruction ahead holds the dependent instruction in decode for exactly two cycles, and a writer two instructions ahead for exactly one.
- R4: A slot whose write flag is 0 never causes a stall. A writer that has reached write-back has no input to this block and so never stalls decode.
- R5: Source register number 0 never causes a stall, whatever the destinations and write flags.
- R6: While `idex_bubble` is 1, both `pc_write_en` and `ifid_write_en` are 0.
- R7: While `idex_bubble` is 1, `idex_ctrl` is all zeros. Otherwise `idex_ctrl` equals `dec_ctrl`.
- R8: When no source matches, `pc_write_en` and `ifid_write_en` are 1 and `idex_bubble` is 0.
- R9: Each source field of `dec_src_regs` (source k in bits [k*REG_W +: REG_W]) is checked independently. Matches in both older slots at the same time still give one stall indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_regs | input | NUM_SRC*REG_W | Source register numbers of the instruction in decode; source k in bits [k*REG_W +: REG_W] |
| ex_dst_reg | input | REG_W | Destination register of the instruction in the decode/execute register |
| ex_reg_write | input | 1 | Register-write flag of that instruction |
| mem_dst_reg | input | REG_W | Destination register of the instruction in the execute/memory register |
| mem_reg_write | input | 1 | Register-write flag of that instruction |
| dec_ctrl | input | CTRL_W | Control word produced by decode for the current instruction |
| pc_write_en | output | 1 | Program counter may load its next value |
| ifid_write_en | output | 1 | Fetch/decode register may load a new instruction |
| idex_bubble | output | 1 | A bubble is being inserted into decode/execute |
| idex_ctrl | output | CTRL_W | Control word to load into decode/execute (zero on a bubble) |

## Verification
The bench builds the block with REG_W=3, NUM_SRC=2 and CTRL_W=6. With these values, every combination of two source numbers, two destinations and two write flags can be applied in an exhaustive sweep of 16384 input patterns. That sweep covers the register-0 exclusion, matches on each source field and simultaneous matches in both slots. A small model of the surrounding pipeline then moves the writer through the stages, to show the two-cycle and one-cycle stall lengths that arise without any counter.

// File: rtl/interlock_pkg.sv
`timescale 1ns/1ps
package interlock_pkg;

    // Hazard kind seen by the decode stage. The value ordering reflects how
    // many bubble cycles remain before the dependent instruction may leave.
    typedef enum logic [1:0] {
        HZ_CLEAR = 2'd0,   // nothing pending, decode proceeds
        HZ_FAR   = 2'd1,   // writer in execute/memory: one bubble left
        HZ_NEAR  = 2'd2    // writer in decode/execute: two bubbles left
    } hazard_kind_e;

endpackage

// File: rtl/src_match_unit.sv
`timescale 1ns/1ps
// Compares one decode source register against one older pipeline slot.
module src_match_unit #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_reg,
    input  logic [REG_W-1:0] slot_dst,
    input  logic             slot_write,
    output logic             hit
);
    logic src_live;

    // Register 0 is hard-wired and never carries a dependency.
    assign src_live = (src_reg != '0);
    assign hit      = slot_write && src_live && (src_reg == slot_dst);

endmodule

// File: rtl/hazard_classify.sv
`timescale 1ns/1ps
// Reduces per-source match bits into a single hazard kind; the nearest
// writer takes precedence because it needs the longer wait.
module hazard_classify
    import interlock_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] near_hits,
    input  logic [NUM_SRC-1:0] far_hits,
    output hazard_kind_e       kind
);
    logic any_near;
    logic any_far;

    assign any_near = |near_hits;
    assign any_far  = |far_hits;

    always_comb begin
        unique case ({any_near, any_far})
            2'b10, 2'b11: kind = HZ_NEAR;
            2'b01:        kind = HZ_FAR;
            default:      kind = HZ_CLEAR;
        endcase
    end

endmodule

// File: rtl/stall_ctrl.sv
`timescale 1ns/1ps
// Decodes the hazard kind into the enables for fetch and decode.
module stall_ctrl
    import interlock_pkg::*;
(
    input  hazard_kind_e kind,
    output logic         pc_we,
    output logic         ifid_we,
    output logic         bubble
);
    always_comb begin
        unique case (kind)
            HZ_CLEAR: begin
                pc_we   = 1'b1;
                ifid_we = 1'b1;
                bubble  = 1'b0;
            end
            HZ_FAR, HZ_NEAR: begin
                pc_we   = 1'b0;
                ifid_we = 1'b0;
                bubble  = 1'b1;
            end
            default: begin
                pc_we   = 1'b0;
                ifid_we = 1'b0;
                bubble  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bubble_mux.sv
`timescale 1ns/1ps
// Zeroes every control field heading into decode/execute on a bubble.
module bubble_mux #(
    parameter int CTRL_W = 8
) (
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic              bubble,
    output logic [CTRL_W-1:0] ctrl_out
);
    for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
        assign ctrl_out[b] = ctrl_in[b] & ~bubble;
    end

endmodule

// File: rtl/interlock_unit.sv
`timescale 1ns/1ps
module interlock_unit
    import interlock_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2,
    parameter int CTRL_W  = 8
) (
    input  logic [NUM_SRC*REG_W-1:0] dec_src_regs,
    input  logic [REG_W-1:0]         ex_dst_reg,
    input  logic                     ex_reg_write,
    input  logic [REG_W-1:0]         mem_dst_reg,
    input  logic                     mem_reg_write,
    input  logic [CTRL_W-1:0]        dec_ctrl,
    output logic                     pc_write_en,
    output logic                     ifid_write_en,
    output logic                     idex_bubble,
    output logic [CTRL_W-1:0]        idex_ctrl
);
    localparam int SRC_BITS = NUM_SRC * REG_W;

    logic [NUM_SRC-1:0] near_hits;
    logic [NUM_SRC-1:0] far_hits;
    hazard_kind_e       kind;

    // One comparator pair per source operand.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        src_match_unit #(.REG_W(REG_W)) u_near (
            .src_reg   (dec_src_regs[k*REG_W +: REG_W]),
            .slot_dst  (ex_dst_reg),
            .slot_write(ex_reg_write),
            .hit       (near_hits[k])
        );
        src_match_unit #(.REG_W(REG_W)) u_far (
            .src_reg   (dec_src_regs[k*REG_W +: REG_W]),
            .slot_dst  (mem_dst_reg),
            .slot_write(mem_reg_write),
            .hit       (far_hits[k])
        );
    end

    hazard_classify #(.NUM_SRC(NUM_SRC)) u_classify (
        .near_hits(near_hits),
        .far_hits (far_hits),
        .kind     (kind)
    );

    stall_ctrl u_stall (
        .kind   (kind),
        .pc_we  (pc_write_en),
        .ifid_we(ifid_write_en),
        .bubble (idex_bubble)
    );

    bubble_mux #(.CTRL_W(CTRL_W)) u_mux (
        .ctrl_in (dec_ctrl),
        .bubble  (idex_bubble),
        .ctrl_out(idex_ctrl)
    );

    // Assertions: relate outputs of separate submodules at the block edge.
    logic srcs_all_zero;
    always_comb begin
        srcs_all_zero = (dec_src_regs == {SRC_BITS{1'b0}});

        p_zero_src_quiet_r5: assert (!(srcs_all_zero && idex_bubble))
            else $error("register 0 sources raised a stall");

        p_no_writer_quiet_r4: assert (ex_reg_write || mem_reg_write || !idex_bubble)
            else $error("stall raised with no writing slot");

        p_freeze_on_bubble_r6: assert (!idex_bubble || (!pc_write_en && !ifid_write_en))
            else $error("fetch not frozen during bubble");

        p_ctrl_zero_r7: assert (!idex_bubble || (idex_ctrl == '0))
            else $error("control word not cleared on bubble");

        p_ctrl_pass_r8: assert (idex_bubble || (idex_ctrl == dec_ctrl && pc_write_en))
            else $error("control word altered without a stall");
    end

endmodule

// File: tb/interlock_unit_tb.sv
`timescale 1ns/1ps
module interlock_unit_tb;
    localparam int RW = 3;
    localparam int NS = 2;
    localparam int CW = 6;
    localparam int NVEC = 11;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [NS*RW-1:0] src_regs;
    logic [RW-1:0]    ex_dst, mem_dst;
    logic             ex_w, mem_w;
    logic [CW-1:0]    ctrl_in;
    logic             pc_we, ifid_we, bubble;
    logic [CW-1:0]    ctrl_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    interlock_unit #(.REG_W(RW), .NUM_SRC(NS), .CTRL_W(CW)) u_dut (
        .dec_src_regs (src_regs),
        .ex_dst_reg   (ex_dst),
        .ex_reg_write (ex_w),
        .mem_dst_reg  (mem_dst),
        .mem_reg_write(mem_w),
        .dec_ctrl     (ctrl_in),
        .pc_write_en  (pc_we),
        .ifid_write_en(ifid_we),
        .idex_bubble  (bubble),
        .idex_ctrl    (ctrl_out)
    );

    // {req, src0, src1, ex_dst, ex_w, mem_dst, mem_w, expect_stall}
    localparam logic [18:0] VEC [NVEC] = '{
        {4'd1, 3'd3, 3'd1, 3'd3, 1'b1, 3'd0, 1'b0, 1'b1},  // R1 via source 0
        {4'd1, 3'd7, 3'd7, 3'd7, 1'b1, 3'd0, 1'b0, 1'b1},  // R1 both sources same
        {4'd9, 3'd2, 3'd5, 3'd5, 1'b1, 3'd0, 1'b0, 1'b1},  // R9 via source 1
        {4'd2, 3'd4, 3'd0, 3'd0, 1'b0, 3'd4, 1'b1, 1'b1},  // R2 via source 0
        {4'd2, 3'd1, 3'd6, 3'd2, 1'b0, 3'd6, 1'b1, 1'b1},  // R2 via source 1
        {4'd4, 3'd3, 3'd3, 3'd3, 1'b0, 3'd3, 1'b0, 1'b0},  // R4 flags clear
        {4'd5, 3'd0, 3'd0, 3'd0, 1'b1, 3'd0, 1'b1, 1'b0},  // R5 all zero
        {4'd5, 3'd0, 3'd7, 3'd0, 1'b1, 3'd0, 1'b1, 1'b0},  // R5 one zero source
        {4'd9, 3'd2, 3'd7, 3'd7, 1'b1, 3'd2, 1'b1, 1'b1},  // R9 both slots match
        {4'd8, 3'd1, 3'd2, 3'd3, 1'b1, 3'd4, 1'b1, 1'b0},  // R8 no match
        {4'd8, 3'd5, 3'd6, 3'd7, 1'b1, 3'd1, 1'b0, 1'b0}   // R8 no match
    };

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic check_outputs(input string req, input bit exp_stall);
        check(req, int'(bubble), int'(exp_stall));
        check({req, " (R6/R8 enables)"}, int'({pc_we, ifid_we}),
              exp_stall ? 0 : 3);
        check({req, " (R7 ctrl)"}, int'(ctrl_out),
              exp_stall ? 0 : int'(ctrl_in));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int stalls;
        // Initial quiet state: R8
        src_regs = '0; ex_dst = '0; mem_dst = '0; ex_w = 0; mem_w = 0;
        ctrl_in = 6'h2D;
        #1;
        check_outputs("R8 initial", 1'b0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            src_regs = {VEC[i][11:9], VEC[i][14:12]};
            ex_dst   = VEC[i][8:6];
            ex_w     = VEC[i][5];
            mem_dst  = VEC[i][4:2];
            mem_w    = VEC[i][1];
            ctrl_in  = CW'(6'h15 + i);
            #1;
            check_outputs($sformatf("R%0d vector %0d", VEC[i][18:15], i), VEC[i][0]);
        end

        // Exhaustive sweep: R1 R2 R4 R5 R9
        for (int s0 = 0; s0 < 8; s0++)
        for (int s1 = 0; s1 < 8; s1++)
        for (int ed = 0; ed < 8; ed++)
        for (int md = 0; md < 8; md++)
        for (int fl = 0; fl < 4; fl++) begin
            bit exp;
            src_regs = {3'(s1), 3'(s0)};
            ex_dst = 3'(ed); mem_dst = 3'(md);
            ex_w = fl[0]; mem_w = fl[1];
            ctrl_in = 6'(s0 * 8 + s1) | 6'h01;
            exp = (s0 != 0 && ((fl[0] && s0 == ed) || (fl[1] && s0 == md))) ||
                  (s1 != 0 && ((fl[0] && s1 == ed) || (fl[1] && s1 == md)));
            #1;
            check(exp ? "R1/R2/R9 sweep stall" : "R4/R5 sweep quiet",
                  int'(bubble), int'(exp));
            if (bubble) check("R6 sweep freeze", int'({pc_we, ifid_we}), 0);
        end

        // R3: writer one instruction ahead, pipeline advancing
        ctrl_in = 6'h3F;
        @(negedge clk);
        src_regs = {3'd5, 3'd3};
        ex_dst = 3'd3; ex_w = 1; mem_dst = 3'd0; mem_w = 0;
        stalls = 0;
        for (int c = 0; c < 6; c++) begin
            #1;
            if (!bubble) break;
            stalls++;
            @(posedge clk);
            mem_dst = ex_dst; mem_w = ex_w;   // writer advances
            ex_w = 0;                          // bubble enters ID/EX
            @(negedge clk);
        end
        check("R3 distance one bubbles", stalls, 2);
        check("R4 writer in write-back, R8 release", int'({pc_we, ifid_we}), 3);

        // R3: writer two instructions ahead
        @(negedge clk);
        src_regs = {3'd5, 3'd3};
        ex_dst = 3'd6; ex_w = 1; mem_dst = 3'd3; mem_w = 1;
        stalls = 0;
        for (int c = 0; c < 6; c++) begin
            #1;
            if (!bubble) break;
            stalls++;
            @(posedge clk);
            mem_dst = ex_dst; mem_w = ex_w;
            ex_w = 0;
            @(negedge clk);
        end
        check("R3 distance two bubbles", stalls, 1);
        check("R7 ctrl passes after release", int'(ctrl_out), int'(ctrl_in));

        finish_run();
    end

endmodule